// File: doc/BRIEF.md
# Pipelined Fletcher Checksum Unit

This block reduces a 128-bit message to a 32-bit order-sensitive checksum. The message holds eight 16-bit words. Two running sums start at zero and take the words in lane order. For each word, the first sum adds the word. The second sum then adds the updated first sum. Both sums wrap modulo 65536. Because the second sum weights early words more heavily, the same words in a different order give a different result.

Messages enter through a valid/ready receive port into a small queue. From the queue they pass through eight combinational step stages. They then cross a configurable number of pipeline registers and leave on a valid/ready send port. With the sink ready, the unit accepts one message per cycle and returns results in arrival order. When the sink stalls, results are held and backpressure travels back to the receive port. No message is lost or repeated.

Top module: `fletcher_cksum_unit`

## Requirements
- R1: Word lane i of `recv_msg` is bits [16*i+15:16*i], and lane 0 is consumed first. A message whose only nonzero lane is lane 0, holding 1, yields 0x00080001. The same value alone in lane 5 yields 0x00030001.
- R2: Both sums wrap modulo 65536, and each second-sum update uses the updated first sum. Eight lanes of 0xFFFF yield 0xFFDCFFF8.
- R3: The result carries the second sum in bits [31:16] and the first sum in bits [15:0]. Lanes 0..7 holding 1..8 yield 0x00780024.
- R4: Reordering the words changes the result. Lanes 0..7 holding 8..1 yield 0x00cc0024.
- R5: Suppose the unit is empty and `send_ready` is high. If a message is accepted at a rising edge, `send_valid` first rises after NSTAGES-1 further rising edges.
- R6: With `send_ready` held high, `recv_ready` stays high and one message per cycle is accepted and returned, with no bubbles.
- R7: While `send_valid` is high and `send_ready` is low, `send_valid` stays high and `send_data` stays unchanged. Results leave in arrival order, each exactly once.
- R8: `recv_ready` goes low only when the input queue is full. With the sink stalled, exactly QDEPTH+NSTAGES-1 messages are accepted before `recv_ready` drops.
- R9: A synchronous `rst` empties the queue and every pipeline stage. In the cycle after reset, `send_valid` is low and `recv_ready` is high, and messages that were in flight are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| recv_valid | input | 1 | A message is offered on `recv_msg` |
| recv_ready | output | 1 | The unit can take a message this cycle |
| recv_msg | input | 128 | Eight 16-bit words, lane 0 in the low bits |
| send_valid | output | 1 | A checksum is presented on `send_data` |
| send_ready | input | 1 | The sink takes the checksum this cycle |
| send_data | output | 32 | Second sum in the upper half, first sum in the lower half |

## Verification
The case most likely to break is a single cycle in which the queue accepts a new message and the last pipeline stage hands a result to the sink. In that same cycle, every middle stage must shift forward by one without losing or repeating an entry. The bench provokes this by streaming messages back to back with the sink always ready. It also toggles `send_ready` irregularly while new messages keep arriving, so that fills and drains land together on many edges. A scoreboard built from the bench's own weighted-sum model judges every result that leaves, in order. A cycle-by-cycle record of `recv_ready` confirms that the coincident cycles never inserted a stall.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

  localparam int WORD_W    = 16;
  localparam int NUM_WORDS = 8;
  localparam int MSG_W     = WORD_W * NUM_WORDS;
  localparam int SUM_W     = 2 * WORD_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    word_t hi;   // weighted (second) sum
    word_t lo;   // plain (first) sum
  } sums_t;

  // One accumulation step: the plain sum absorbs the word, and the
  // weighted sum absorbs the updated plain sum. 16-bit adds wrap mod 2^16.
  function automatic sums_t accum_step(sums_t acc, word_t w);
    sums_t r;
    r.lo = acc.lo + w;
    r.hi = acc.hi + r.lo;
    return r;
  endfunction

endpackage

// File: rtl/fcs_in_queue.sv
module fcs_in_queue #(
  parameter int W     = 128,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  slots [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] fill;
  logic          push, pop;

  assign in_ready  = (fill != CW'(DEPTH));
  assign out_valid = (fill != '0);
  assign out_data  = slots[rd_ptr];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[wr_ptr] <= in_data;
  end

endmodule

// File: rtl/fcs_step.sv
module fcs_step
  import fcs_pkg::*;
(
  input  sums_t acc_i,
  input  word_t word_i,
  output sums_t acc_o
);
  assign acc_o = accum_step(acc_i, word_i);
endmodule

// File: rtl/fcs_chain.sv
module fcs_chain
  import fcs_pkg::*;
#(
  parameter int LANES = NUM_WORDS
) (
  input  logic [LANES*WORD_W-1:0] msg_i,
  output logic [SUM_W-1:0]        cksum_o
);
  sums_t acc [LANES+1];

  assign acc[0] = '0;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    fcs_step u_step (
      .acc_i  (acc[g]),
      .word_i (msg_i[g*WORD_W +: WORD_W]),
      .acc_o  (acc[g+1])
    );
  end

  assign cksum_o = acc[LANES];
endmodule

// File: rtl/fcs_pipe.sv
module fcs_pipe #(
  parameter int W    = 32,
  parameter int NREG = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  // Position 0 is the pipe input; position k+1 is the output of register k.
  logic         pv  [NREG+1];
  logic [W-1:0] pd  [NREG+1];
  logic         adv [NREG+1];   // adv[k]: register k may load this cycle

  assign pv[0]     = in_valid;
  assign pd[0]     = in_data;
  assign adv[NREG] = out_ready;

  for (genvar k = 0; k < NREG; k++) begin : g_stage
    logic         vld_q;
    logic [W-1:0] dat_q;

    assign adv[k]  = !vld_q || adv[k+1];
    assign pv[k+1] = vld_q;
    assign pd[k+1] = dat_q;

    always_ff @(posedge clk) begin
      if (rst)         vld_q <= 1'b0;
      else if (adv[k]) vld_q <= pv[k];
    end

    always_ff @(posedge clk) begin
      if (adv[k] && pv[k]) dat_q <= pd[k];
    end
  end

  assign in_ready  = adv[0];
  assign out_valid = pv[NREG];
  assign out_data  = pd[NREG];
endmodule

// File: rtl/fletcher_cksum_unit.sv
module fletcher_cksum_unit
  import fcs_pkg::*;
#(
  parameter int NSTAGES = 3,
  parameter int QDEPTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             recv_valid,
  output logic             recv_ready,
  input  logic [MSG_W-1:0] recv_msg,
  output logic             send_valid,
  input  logic             send_ready,
  output logic [SUM_W-1:0] send_data
);
  localparam int NREG = NSTAGES - 1;

  logic             q_valid, q_take;
  logic [MSG_W-1:0] q_msg;
  logic [SUM_W-1:0] chain_sum;

  fcs_in_queue #(.W(MSG_W), .DEPTH(QDEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (recv_valid),
    .in_ready  (recv_ready),
    .in_data   (recv_msg),
    .out_valid (q_valid),
    .out_ready (q_take),
    .out_data  (q_msg)
  );

  fcs_chain #(.LANES(NUM_WORDS)) u_chain (
    .msg_i   (q_msg),
    .cksum_o (chain_sum)
  );

  fcs_pipe #(.W(SUM_W), .NREG(NREG)) u_pipe (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (q_valid),
    .in_ready  (q_take),
    .in_data   (chain_sum),
    .out_valid (send_valid),
    .out_ready (send_ready),
    .out_data  (send_data)
  );
endmodule

// File: rtl/fcs_unit_checker.sv
module fcs_unit_checker #(
  parameter int NSTAGES = 3,
  parameter int QDEPTH  = 2
) (
  input logic        clk,
  input logic        rst,
  input logic        recv_valid,
  input logic        recv_ready,
  input logic        send_valid,
  input logic        send_ready,
  input logic [31:0] send_data
);
  localparam int CAP = QDEPTH + NSTAGES - 1;

  logic recv_fire, send_fire;
  int   in_flight;

  assign recv_fire = recv_valid && recv_ready;
  assign send_fire = send_valid && send_ready;

  always_ff @(posedge clk) begin
    if (rst) in_flight <= 0;
    else     in_flight <= in_flight + (recv_fire ? 1 : 0) - (send_fire ? 1 : 0);
  end

  a_r7_hold_valid: assert property (@(posedge clk) disable iff (rst)
    send_valid && !send_ready |=> send_valid);

  a_r7_hold_data: assert property (@(posedge clk) disable iff (rst)
    send_valid && !send_ready |=> $stable(send_data));

  a_r8_flight_cap: assert property (@(posedge clk) disable iff (rst)
    in_flight <= CAP);

  a_r8_ready_only_full: assert property (@(posedge clk) disable iff (rst)
    !recv_ready |-> in_flight >= QDEPTH);

  a_r6_empty_accepts: assert property (@(posedge clk) disable iff (rst)
    in_flight == 0 |-> recv_ready && !send_valid);

  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> !send_valid && recv_ready);

endmodule

bind fletcher_cksum_unit fcs_unit_checker #(.NSTAGES(NSTAGES), .QDEPTH(QDEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .recv_valid (recv_valid),
  .recv_ready (recv_ready),
  .send_valid (send_valid),
  .send_ready (send_ready),
  .send_data  (send_data)
);

// File: tb/fletcher_cksum_unit_test.sv
module fletcher_cksum_unit_test;
  localparam int NST = 3;
  localparam int QD  = 2;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         recv_valid = 1'b0;
  logic         recv_ready;
  logic [127:0] recv_msg = '0;
  logic         send_valid;
  logic         send_ready = 1'b0;
  logic [31:0]  send_data;

  int n_chk = 0, n_bad = 0;
  int wr = 0, rd = 0;
  logic [31:0] expq [256];
  string cur_req = "R7";
  bit done = 0;

  fletcher_cksum_unit #(.NSTAGES(NST), .QDEPTH(QD)) uut (
    .clk(clk), .rst(rst), .recv_valid(recv_valid), .recv_ready(recv_ready),
    .recv_msg(recv_msg), .send_valid(send_valid), .send_ready(send_ready),
    .send_data(send_data)
  );

  always #4 clk = ~clk;

  // Model: plain sum is the word total; weighted sum gives lane i weight 8-i.
  function automatic logic [31:0] model(logic [127:0] m);
    int s_lo = 0, s_hi = 0;
    for (int i = 0; i < 8; i++) begin
      s_lo += int'(m[16*i +: 16]);
      s_hi += (8 - i) * int'(m[16*i +: 16]);
    end
    return {s_hi[15:0], s_lo[15:0]};
  endfunction

  function automatic logic [127:0] mkmsg(int seed);
    logic [127:0] m;
    for (int i = 0; i < 8; i++) m[16*i +: 16] = 16'(seed * 40503 + i * 9973 + (seed >> 3));
    return m;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge with the drives set; returns at the next one.
  task automatic step();
    #1;
    if (!rst) begin
      if (recv_valid && recv_ready) begin
        expq[wr % 256] = model(recv_msg);
        wr++;
      end
      if (send_valid && send_ready) begin
        if (rd == wr) chk({cur_req, " extra result"}, send_data, 32'hxxxxxxxx);
        else chk(cur_req, send_data, expq[rd % 256]);
        rd++;
      end
    end
    @(negedge clk);
  endtask

  task automatic drain();
    recv_valid = 1'b0;
    send_ready = 1'b1;
    for (int i = 0; i < 40 && rd != wr; i++) step();
    chk({cur_req, " all delivered"}, 32'(rd), 32'(wr));
  endtask

  // Offer one message until taken, then watch latency and value.
  task automatic single(string req, logic [127:0] m, logic [31:0] exp);
    int lat = 0;
    cur_req = req;
    send_ready = 1'b1;
    recv_msg = m;
    recv_valid = 1'b1;
    step();
    recv_valid = 1'b0;
    #1;
    while (!send_valid && lat < 20) begin
      step();
      lat++;
      #1;
    end
    chk(req, send_data, exp);
    chk("R5 latency", 32'(lat), 32'(NST - 1));
    step();
  endtask

  task automatic t_reset();
    #1;
    chk("R9 send_valid after reset", 32'(send_valid), 0);
    chk("R9 recv_ready after reset", 32'(recv_ready), 1);
  endtask

  task automatic t_values();
    single("R3", 128'h0008_0007_0006_0005_0004_0003_0002_0001, 32'h0078_0024);
    single("R4", 128'h0001_0002_0003_0004_0005_0006_0007_0008, 32'h00cc_0024);
    single("R1", 128'h0000_0000_0000_0000_0000_0000_0000_0001, 32'h0008_0001);
    single("R1", 128'h0000_0000_0001_0000_0000_0000_0000_0000, 32'h0003_0001);
    single("R2", {8{16'hFFFF}}, 32'hFFDC_FFF8);
  endtask

  task automatic t_stream();
    int stalls = 0;
    int base = wr;
    cur_req = "R6";
    send_ready = 1'b1;
    for (int i = 0; i < 20; i++) begin
      recv_msg = mkmsg(i + 1);
      recv_valid = 1'b1;
      #1;
      if (!recv_ready) stalls++;
      step();
    end
    chk("R6 bubbles", 32'(stalls), 0);
    chk("R6 accepted", 32'(wr - base), 20);
    drain();
  endtask

  task automatic t_stall();
    int acc = 0;
    logic [31:0] held;
    cur_req = "R7";
    send_ready = 1'b0;
    for (int i = 0; i < 10; i++) begin
      recv_msg = mkmsg(100 + i);
      recv_valid = 1'b1;
      #1;
      if (recv_ready) acc++;
      step();
    end
    chk("R8 accepted before full", 32'(acc), 32'(QD + NST - 1));
    #1;
    chk("R8 recv_ready low when full", 32'(recv_ready), 0);
    held = send_data;
    recv_valid = 1'b0;
    for (int i = 0; i < 5; i++) step();
    #1;
    chk("R7 held valid", 32'(send_valid), 1);
    chk("R7 held data", send_data, held);
    // Irregular sink with continuing traffic: fills and drains coincide.
    for (int i = 0; i < 60; i++) begin
      send_ready = (i % 3 != 0) && (i % 7 != 5);
      recv_msg = mkmsg(200 + i);
      recv_valid = (i % 4 != 3);
      step();
    end
    drain();
  endtask

  task automatic t_midreset();
    cur_req = "R9";
    send_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      recv_msg = mkmsg(500 + i);
      recv_valid = 1'b1;
      step();
    end
    recv_valid = 1'b0;
    rst = 1'b1;
    step();
    rst = 1'b0;
    wr = 0;
    rd = 0;
    #1;
    chk("R9 send_valid after mid reset", 32'(send_valid), 0);
    chk("R9 recv_ready after mid reset", 32'(recv_ready), 1);
    send_ready = 1'b1;
    for (int i = 0; i < 6; i++) step();
    chk("R9 nothing left after reset", 32'(rd), 0);
    single("R9", 128'h0008_0007_0006_0005_0004_0003_0002_0001, 32'h0078_0024);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_values();
    t_stream();
    t_stall();
    t_midreset();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule